// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block is the control logic for a bank of on/off switch channels. A host loads the channel pattern one bit at a time through a serial data pin and a shift strobe. The bits pass through a shift register. An output latch stage then presents them as parallel switch enables. The latch is transparent while its active-low enable is low and holds its contents while the enable is high. A single active-high clear input empties both the register and the latch at once. The last shift stage drives a serial output, so several controllers can share one strobe and be wired in a chain.

Everything runs in one system clock domain. The shift strobe is sampled, and each low-to-high transition of the strobe moves the register by exactly one place. The latch is modelled as a sampled holding register behind a bypass multiplexer. Its output follows the register combinationally when the enable is low, and it shows the stored value when the enable is high. The channel count is a parameter, so a chain of k 16-channel parts can also be modelled as one instance with 16·k channels.

Top module: `serial_switch_ctrl`

## Requirements
- R1: A low-to-high transition of `sclk_i`, seen at one `clk_i` edge, updates the shift register at the next `clk_i` rising edge. Stage 0 takes `sdi_i` and every stage n takes the old value of stage n-1.
- R2: Bit value 1 in a channel position turns `sw_o[i]` on (1). Bit value 0 turns it off (0).
- R3: `sdo_o` equals the last stage (index NCh-1). After NCh shifts, `sdo_o` shows the first bit shifted in.
- R4: After NCh shifts, the most recently shifted bit controls `sw_o[0]`. When a pattern is sent MSB first, `sw_o` equals that pattern.
- R5: While `le_ni` is low, `sw_o` follows the shift register in the same cycle, so it changes with every shift.
- R6: While `le_ni` is high, `sw_o` keeps the register contents from the last cycle in which `le_ni` was low, and shifting does not change it.
- R7: While `clr_i` is high, the register and latch are zero without waiting for a clock edge, and `sw_o` is zero. This takes priority over `le_ni` and over `sclk_i`.
- R8: While `clr_i` is high, `sdo_o` is low.
- R9: In a chain sharing `sclk_i`, a downstream block samples the previous bit of its upstream `sdo_o`. A three-block chain loaded with 48 bits MSB first holds bit 47 at the far block's channel 15.
- R10: While `sclk_i` is held high, only one shift occurs. No shift occurs without a new low-to-high transition.
- R11: While `rst_ni` is low, the register, the latch and the strobe edge detector are cleared, so `sw_o` and `sdo_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdi_i | input | 1 | Serial data in |
| sclk_i | input | 1 | Shift strobe, acts on its rising transition |
| le_ni | input | 1 | Latch enable, active low (low = transparent) |
| clr_i | input | 1 | Asynchronous clear, active high |
| sdo_o | output | 1 | Serial data out (last stage) |
| sw_o | output | NCh | Switch enables, bit i for channel i |

## Verification
The bench loads two asymmetric 16-bit words MSB first with the latch closed, then opens it. This separates a correct bit-to-channel mapping from a reversed or shifted one. It then shifts with the latch held and with it open, which tells a frozen output apart from a rippling one. A clear is raised in the middle of a load, with strobes and an open latch, to test that the clear wins over both. A strobe is held high for several cycles to tell edge-triggered shifting from level-triggered shifting. Three chained instances take a 48-bit word, and a cycle-accurate model compares each cycle to expose any same-edge race in the chain.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  localparam int unsigned DefChannels = 16;
  localparam int unsigned MinChannels = 2;
endpackage

// File: rtl/swctl_edge.sv
module swctl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic pulse_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign pulse_o = strobe_i & ~strobe_q;

  // R10: a held strobe yields a single pulse
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/swctl_shift.sv
module swctl_shift #(
  parameter int unsigned NCh = swctl_pkg::DefChannels
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic           din_i,
  output logic [NCh-1:0] q_o
);
  localparam int unsigned Top = NCh - 1;

  logic [NCh-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)     q <= '0;
    else if (clr_i)  q <= '0;
    else if (step_i) q <= {q[Top-1:0], din_i};
  end

  assign q_o = q;

  a_r1_entry: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    step_i |=> q[0] == $past(din_i));
  a_r1_move: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    step_i |=> q[Top:1] == $past(q[Top-1:0]));
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    !step_i |=> $stable(q));
endmodule

// File: rtl/swctl_latch.sv
module swctl_latch #(
  parameter int unsigned NCh = swctl_pkg::DefChannels
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           le_ni,
  input  logic [NCh-1:0] d_i,
  output logic [NCh-1:0] q_o
);
  logic [NCh-1:0] hold_q;

  for (genvar i = 0; i < NCh; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
      if (!rst_ni)     hold_q[i] <= 1'b0;
      else if (clr_i)  hold_q[i] <= 1'b0;
      else if (!le_ni) hold_q[i] <= d_i[i];
    end
    // transparent bypass while enable is low
    assign q_o[i] = le_ni ? hold_q[i] : d_i[i];
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    le_ni |=> $stable(hold_q));
  a_r5_track: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    !le_ni |=> hold_q == $past(d_i));
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl #(
  parameter int unsigned NCh = swctl_pkg::DefChannels
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sdi_i,
  input  logic           sclk_i,
  input  logic           le_ni,
  input  logic           clr_i,
  output logic           sdo_o,
  output logic [NCh-1:0] sw_o
);
  localparam int unsigned Top = NCh - 1;

  logic           step;
  logic [NCh-1:0] chain_q;

  swctl_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (sclk_i),
    .pulse_o  (step)
  );

  swctl_shift #(.NCh(NCh)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .step_i (step),
    .din_i  (sdi_i),
    .q_o    (chain_q)
  );

  swctl_latch #(.NCh(NCh)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .le_ni  (le_ni),
    .d_i    (chain_q),
    .q_o    (sw_o)
  );

  assign sdo_o = chain_q[Top];

  initial begin
    a_r11_width: assert (NCh >= swctl_pkg::MinChannels);
  end

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> sw_o == '0);
  a_r8_clear_sdo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !sdo_o);
  a_r3_sdo: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    step |=> sdo_o == $past(chain_q[Top-1]));
  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    le_ni && $past(le_ni) |-> $stable(sw_o));
endmodule

// File: tb/serial_switch_ctrl_tb.sv
module serial_switch_ctrl_tb;
  localparam int N = 16;
  localparam int L = 3 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0, sclk = 1'b0, le_n = 1'b1, clr = 1'b0;
  logic sdo0, sdo1, sdo2;
  logic [N-1:0] sw0, sw1, sw2;
  int errors = 0, checks = 0;
  string phase = "R11";
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_switch_ctrl #(.NCh(N)) u_dut (.clk_i(clk), .rst_ni(rst_n), .sdi_i(sdi),
    .sclk_i(sclk), .le_ni(le_n), .clr_i(clr), .sdo_o(sdo0), .sw_o(sw0));
  serial_switch_ctrl #(.NCh(N)) u_mid (.clk_i(clk), .rst_ni(rst_n), .sdi_i(sdo0),
    .sclk_i(sclk), .le_ni(le_n), .clr_i(clr), .sdo_o(sdo1), .sw_o(sw1));
  serial_switch_ctrl #(.NCh(N)) u_far (.clk_i(clk), .rst_ni(rst_n), .sdi_i(sdo1),
    .sclk_i(sclk), .le_ni(le_n), .clr_i(clr), .sdo_o(sdo2), .sw_o(sw2));

  // behavioural reference: one long bit queue plus a held copy
  bit mq[L];
  bit mh[L];
  bit sclk_prev;

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < L; i++) begin mq[i] = 1'b0; mh[i] = 1'b0; end
      sclk_prev = rst_n ? sclk : 1'b0;
    end else begin
      if (!le_n) for (int i = 0; i < L; i++) mh[i] = mq[i];
      if (sclk && !sclk_prev) begin
        for (int i = L - 1; i > 0; i--) mq[i] = mq[i-1];
        mq[0] = sdi;
      end
      sclk_prev = sclk;
    end
  end

  task automatic chk(string req, logic [L-1:0] got, logic [L-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // per-cycle comparison, mid-cycle
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [L-1:0] e;
      for (int i = 0; i < L; i++) e[i] = le_n ? mh[i] : mq[i];
      chk({phase, " cycle"}, {sw2, sw1, sw0}, e);
      chk({phase, " sdo"}, {45'd0, sdo2, sdo1, sdo0},
          {45'd0, mq[L-1], mq[2*N-1], mq[N-1]});
    end
  end

  task automatic shift_bit(logic b);
    @(negedge clk); sdi = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] pa, pb, held;
    logic [L-1:0] pc;
    pa = 16'hA5C3;
    pb = 16'h1E69;
    pc = 48'hC3_5A_0F_96_E1_7D;
    repeat (3) @(negedge clk);
    chk("R11 reset sw", {sw2, sw1, sw0}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {45'd0, sdo2, sdo1, sdo0}, '0);

    // R4/R2: closed latch, load MSB first, then open
    phase = "R6";
    for (int i = N - 1; i >= 0; i--) shift_bit(pa[i]);
    chk("R6 frozen during load", {32'd0, sw0}, '0);
    chk("R3 sdo first bit", {47'd0, sdo0}, {47'd0, pa[N-1]});
    @(negedge clk); le_n = 1'b0;
    @(negedge clk); le_n = 1'b1;
    @(negedge clk);
    chk("R4 mapping pa", {32'd0, sw0}, {32'd0, pa});
    chk("R2 channel 0 on", {47'd0, sw0[0]}, 48'd1);
    chk("R2 channel 2 off", {47'd0, sw0[2]}, 48'd0);

    // R6: shifting while held
    for (int i = 0; i < 5; i++) shift_bit(1'b0);
    chk("R6 held after shifts", {32'd0, sw0}, {32'd0, pa});

    // R5: open latch ripples
    phase = "R5";
    le_n = 1'b0;
    held = pa << 5;
    @(negedge clk);
    chk("R5 transparent", {32'd0, sw0}, {32'd0, held});
    shift_bit(1'b1);
    chk("R5 ripple 1", {32'd0, sw0}, {32'd0, held << 1 | 16'd1});
    shift_bit(1'b0);
    chk("R5 ripple 2", {32'd0, sw0}, {32'd0, held << 2 | 16'd2});
    le_n = 1'b1;

    // R7/R8: clear mid-load with strobe and open latch
    phase = "R7";
    for (int i = N - 1; i >= 9; i--) shift_bit(pb[i]);
    le_n = 1'b0;
    @(negedge clk); #1 clr = 1'b1; sdi = 1'b1;
    #0.5;
    chk("R7 async clear", {sw2, sw1, sw0}, '0);
    chk("R8 sdo cleared", {45'd0, sdo2, sdo1, sdo0}, '0);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    chk("R7 priority over strobe", {sw2, sw1, sw0}, '0);
    clr = 1'b0;
    le_n = 1'b1;
    @(negedge clk);

    // R10: held strobe, one shift
    phase = "R10";
    le_n = 1'b0;
    @(negedge clk); sdi = 1'b1; sclk = 1'b1;
    repeat (4) @(negedge clk);
    sdi = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
    chk("R10 single shift", {32'd0, sw0}, 48'd1);
    le_n = 1'b1;

    // R1: reload pb and check entry
    phase = "R1";
    for (int i = N - 1; i >= 0; i--) shift_bit(pb[i]);
    le_n = 1'b0;
    @(negedge clk);
    chk("R1 load pb", {32'd0, sw0}, {32'd0, pb});
    le_n = 1'b1;

    // R9: three-block chain, 48 bits MSB first
    phase = "R9";
    for (int i = L - 1; i >= 0; i--) shift_bit(pc[i]);
    @(negedge clk); le_n = 1'b0;
    @(negedge clk); le_n = 1'b1;
    @(negedge clk);
    chk("R9 chain 48 bits", {sw2, sw1, sw0}, pc);
    chk("R9 far ch15 first bit", {47'd0, sw2[N-1]}, {47'd0, pc[L-1]});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule